// File: doc/BRIEF.md
# Two-Way In-Order Issue Pairing Unit

This block sits between the decode stage and the two execution pipes of an in-order core that can issue two instructions per cycle. Each cycle it looks at the two oldest pre-decoded instructions, the older one (I1) and the one directly after it (I2). It decides whether I1 goes alone to the primary pipe (U) or whether I1 goes to U and I2 goes to the secondary pipe (V). The decision, plus the number of instructions taken from the decode buffer, is registered into the issue latches on the rising clock edge.

Integer and floating-point pairs follow separate rule sets. An integer pair needs two simple instructions with no register hazard between them, no branch in the first slot, no prefix on the second instruction, and no instruction that has both a displacement and an immediate. A floating-point pair is allowed only when the second instruction is a register exchange and the first is one of a small set of arithmetic, load, compare and sign operations. An integer instruction and a floating-point instruction never issue together. A stall input freezes issue while the decode stage holds its outputs.

Top module: `pair_issue_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, u_valid, v_valid and consumed are all 0.
- R2: If stall was high, or I1 was not valid, at a clock edge, then after that edge u_valid=0, v_valid=0 and consumed=0.
- R3: If I1 was valid, I2 was not valid and stall was low at an edge, then after that edge u_valid=1, v_valid=0 and consumed=1. Any pairing decision shows up as (u_valid,v_valid,consumed) = (1,1,2), and single issue shows up as (1,0,1).
- R4: Two integer instructions (is_fp=0 on both) pair only if both have simple=1 and I1 has jump=0.
- R5: An integer pair is refused when I1 has a valid destination equal to any valid source of I2. A comparison takes part only when both of its valid bits are set.
- R6: An integer pair is refused when both destinations are valid and equal.
- R7: An integer pair is refused when either instruction has both disp=1 and imm=1.
- R8: An integer pair is refused when I2 has prefix=1. A prefix on I1 alone does not prevent pairing.
- R9: An instruction with is_fp=1 never pairs with an instruction with is_fp=0, in either order.
- R10: Two floating-point instructions pair only when I2's fp_op is 10 (exchange) and I1's fp_op is in 0..9 (0 load, 1 add, 2 subtract, 3 multiply, 4 divide, 5 compare, 6 unordered compare, 7 test, 8 absolute value, 9 change sign). The simple, jump, prefix, disp, imm and register fields have no effect on a floating-point pair.
- R11: The outputs are registered: a decision appears one clock edge after its inputs are sampled. v_valid=1 always implies u_valid=1, and consumed equals u_valid+v_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hold issue for this cycle |
| i1_valid | input | 1 | I1 present |
| i1_is_fp | input | 1 | I1 is floating point |
| i1_simple | input | 1 | I1 is hardwired single-cycle |
| i1_jump | input | 1 | I1 is a branch |
| i1_prefix | input | 1 | I1 carries a prefix |
| i1_disp | input | 1 | I1 has a displacement |
| i1_imm | input | 1 | I1 has an immediate |
| i1_dst | input | REG_W | I1 destination register |
| i1_dst_vld | input | 1 | I1 writes a register |
| i1_src | input | NUM_SRC*REG_W | I1 source registers, source k at bits [k*REG_W +: REG_W] |
| i1_src_vld | input | NUM_SRC | I1 source valid bits |
| i1_fp_op | input | FP_OP_W | I1 floating-point operation category |
| i2_valid | input | 1 | I2 present |
| i2_is_fp | input | 1 | I2 is floating point |
| i2_simple | input | 1 | I2 is hardwired single-cycle |
| i2_jump | input | 1 | I2 is a branch |
| i2_prefix | input | 1 | I2 carries a prefix |
| i2_disp | input | 1 | I2 has a displacement |
| i2_imm | input | 1 | I2 has an immediate |
| i2_dst | input | REG_W | I2 destination register |
| i2_dst_vld | input | 1 | I2 writes a register |
| i2_src | input | NUM_SRC*REG_W | I2 source registers |
| i2_src_vld | input | NUM_SRC | I2 source valid bits |
| i2_fp_op | input | FP_OP_W | I2 floating-point operation category |
| u_valid | output | 1 | Instruction issued to U pipe |
| v_valid | output | 1 | Instruction issued to V pipe |
| consumed | output | 2 | Instructions taken this cycle (0, 1 or 2) |

## Verification
The register hazard logic is tried with a full sweep of every destination/source index combination and every valid-bit setting at a two-bit register width. This separates true RAW and WAW matches from coincidences on operands that are not valid, and from matches against I2's destination used as a source. Every pair of floating-point operation codes is swept so that the eligible-first-slot set, the exchange code and the neighbouring unused codes can all be told apart. Directed cases isolate each integer rule by starting from a pairable baseline and breaking exactly one condition. Stall, empty-slot and mixed-class cases follow. Random pairs with all fields varied then probe interactions between the rules against an arithmetic reference.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

    // Floating-point operation categories; codes 0..9 may lead a pair.
    typedef enum logic [3:0] {
        FOP_LOAD  = 4'd0,
        FOP_ADD   = 4'd1,
        FOP_SUB   = 4'd2,
        FOP_MUL   = 4'd3,
        FOP_DIV   = 4'd4,
        FOP_CMP   = 4'd5,
        FOP_UCMP  = 4'd6,
        FOP_TST   = 4'd7,
        FOP_ABS   = 4'd8,
        FOP_CHS   = 4'd9,
        FOP_XCH   = 4'd10,
        FOP_OTHER = 4'd15
    } fp_op_e;

    localparam logic [3:0] FOP_LEAD_MAX = 4'd9;

    typedef struct packed {
        logic       u_vld;
        logic       v_vld;
        logic [1:0] cnt;
    } issue_t;

endpackage

// File: rtl/pair_hazard_cmp.sv
module pair_hazard_cmp #(
    parameter int REG_W   = 3,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_W-1:0]         a_dst,
    input  logic                     a_dst_vld,
    input  logic [REG_W-1:0]         b_dst,
    input  logic                     b_dst_vld,
    input  logic [NUM_SRC*REG_W-1:0] b_src,
    input  logic [NUM_SRC-1:0]       b_src_vld,
    output logic                     raw_hit,
    output logic                     waw_hit
);
    logic [NUM_SRC-1:0] src_hit;

    // One comparator per source operand of the younger instruction.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign src_hit[k] = a_dst_vld && b_src_vld[k] &&
                            (a_dst == b_src[k*REG_W +: REG_W]);
    end

    assign raw_hit = |src_hit;
    assign waw_hit = a_dst_vld && b_dst_vld && (a_dst == b_dst);
endmodule

// File: rtl/pair_int_rules.sv
module pair_int_rules #(
    parameter int REG_W   = 3,
    parameter int NUM_SRC = 2
) (
    input  logic                     a_simple,
    input  logic                     a_jump,
    input  logic                     a_disp,
    input  logic                     a_imm,
    input  logic [REG_W-1:0]         a_dst,
    input  logic                     a_dst_vld,
    input  logic                     b_simple,
    input  logic                     b_prefix,
    input  logic                     b_disp,
    input  logic                     b_imm,
    input  logic [REG_W-1:0]         b_dst,
    input  logic                     b_dst_vld,
    input  logic [NUM_SRC*REG_W-1:0] b_src,
    input  logic [NUM_SRC-1:0]       b_src_vld,
    output logic                     int_ok
);
    logic raw_hit;
    logic waw_hit;
    logic enc_bad;

    pair_hazard_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) hz_i (
        .a_dst     (a_dst),
        .a_dst_vld (a_dst_vld),
        .b_dst     (b_dst),
        .b_dst_vld (b_dst_vld),
        .b_src     (b_src),
        .b_src_vld (b_src_vld),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit)
    );

    // Displacement together with immediate in either slot blocks pairing.
    assign enc_bad = (a_disp && a_imm) || (b_disp && b_imm);

    always_comb begin
        int_ok = a_simple && b_simple && !a_jump && !b_prefix &&
                 !enc_bad && !raw_hit && !waw_hit;
    end
endmodule

// File: rtl/pair_fp_rules.sv
module pair_fp_rules #(
    parameter int FP_OP_W = 4
) (
    input  logic [FP_OP_W-1:0] a_op,
    input  logic [FP_OP_W-1:0] b_op,
    output logic               fp_ok
);
    import pair_issue_pkg::*;

    localparam logic [FP_OP_W-1:0] XCH_CODE  = FP_OP_W'(FOP_XCH);
    localparam logic [FP_OP_W-1:0] LEAD_LAST = FP_OP_W'(FOP_LEAD_MAX);

    logic lead_ok;
    assign lead_ok = (a_op <= LEAD_LAST);
    assign fp_ok   = lead_ok && (b_op == XCH_CODE);
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit #(
    parameter int REG_W   = 3,
    parameter int NUM_SRC = 2,
    parameter int FP_OP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stall,
    input  logic                     i1_valid,
    input  logic                     i1_is_fp,
    input  logic                     i1_simple,
    input  logic                     i1_jump,
    input  logic                     i1_prefix,
    input  logic                     i1_disp,
    input  logic                     i1_imm,
    input  logic [REG_W-1:0]         i1_dst,
    input  logic                     i1_dst_vld,
    input  logic [NUM_SRC*REG_W-1:0] i1_src,
    input  logic [NUM_SRC-1:0]       i1_src_vld,
    input  logic [FP_OP_W-1:0]       i1_fp_op,
    input  logic                     i2_valid,
    input  logic                     i2_is_fp,
    input  logic                     i2_simple,
    input  logic                     i2_jump,
    input  logic                     i2_prefix,
    input  logic                     i2_disp,
    input  logic                     i2_imm,
    input  logic [REG_W-1:0]         i2_dst,
    input  logic                     i2_dst_vld,
    input  logic [NUM_SRC*REG_W-1:0] i2_src,
    input  logic [NUM_SRC-1:0]       i2_src_vld,
    input  logic [FP_OP_W-1:0]       i2_fp_op,
    output logic                     u_valid,
    output logic                     v_valid,
    output logic [1:0]               consumed
);
    import pair_issue_pkg::*;

    logic   int_ok;
    logic   fp_ok;
    logic   pair_ok;
    issue_t iss_d;
    issue_t iss_q;

    pair_int_rules #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) int_i (
        .a_simple  (i1_simple),
        .a_jump    (i1_jump),
        .a_disp    (i1_disp),
        .a_imm     (i1_imm),
        .a_dst     (i1_dst),
        .a_dst_vld (i1_dst_vld),
        .b_simple  (i2_simple),
        .b_prefix  (i2_prefix),
        .b_disp    (i2_disp),
        .b_imm     (i2_imm),
        .b_dst     (i2_dst),
        .b_dst_vld (i2_dst_vld),
        .b_src     (i2_src),
        .b_src_vld (i2_src_vld),
        .int_ok    (int_ok)
    );

    pair_fp_rules #(.FP_OP_W(FP_OP_W)) fp_i (
        .a_op  (i1_fp_op),
        .b_op  (i2_fp_op),
        .fp_ok (fp_ok)
    );

    // Mixed classes never pair; each class uses its own rule set.
    always_comb begin
        unique case ({i1_is_fp, i2_is_fp})
            2'b00:   pair_ok = int_ok;
            2'b11:   pair_ok = fp_ok;
            default: pair_ok = 1'b0;
        endcase
    end

    always_comb begin
        iss_d = '0;
        if (!stall && i1_valid) begin
            iss_d.u_vld = 1'b1;
            iss_d.cnt   = 2'd1;
            if (i2_valid && pair_ok) begin
                iss_d.v_vld = 1'b1;
                iss_d.cnt   = 2'd2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign u_valid  = iss_q.u_vld;
    assign v_valid  = iss_q.v_vld;
    assign consumed = iss_q.cnt;

    // R11
    v_implies_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_valid |-> u_valid);
    // R11
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consumed == 2'(u_valid) + 2'(v_valid));
    // R2
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || !i1_valid) |=> (!u_valid && !v_valid));
    // R9
    mixed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i1_is_fp != i2_is_fp) |=> !v_valid);
    // R8
    prefix_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!i1_is_fp && !i2_is_fp && i2_prefix) |=> !v_valid);
    // R4
    jump_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!i1_is_fp && !i2_is_fp && i1_jump) |=> !v_valid);
    // R3
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !i2_valid |=> !v_valid);
endmodule

// File: tb/pair_issue_unit_tb_top.sv
`timescale 1ns/1ps
module pair_issue_unit_tb_top;
    localparam int RW = 2;
    localparam int NS = 2;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall;
    logic a_v, a_fp, a_s, a_j, a_p, a_d, a_i, a_dv;
    logic b_v, b_fp, b_s, b_j, b_p, b_d, b_i, b_dv;
    logic [RW-1:0] a_dst, b_dst;
    logic [NS*RW-1:0] a_src, b_src;
    logic [NS-1:0] a_sv, b_sv;
    logic [OW-1:0] a_op, b_op;
    logic u_valid, v_valid;
    logic [1:0] consumed;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pair_issue_unit #(.REG_W(RW), .NUM_SRC(NS), .FP_OP_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .i1_valid(a_v), .i1_is_fp(a_fp), .i1_simple(a_s), .i1_jump(a_j),
        .i1_prefix(a_p), .i1_disp(a_d), .i1_imm(a_i), .i1_dst(a_dst),
        .i1_dst_vld(a_dv), .i1_src(a_src), .i1_src_vld(a_sv), .i1_fp_op(a_op),
        .i2_valid(b_v), .i2_is_fp(b_fp), .i2_simple(b_s), .i2_jump(b_j),
        .i2_prefix(b_p), .i2_disp(b_d), .i2_imm(b_i), .i2_dst(b_dst),
        .i2_dst_vld(b_dv), .i2_src(b_src), .i2_src_vld(b_sv), .i2_fp_op(b_op),
        .u_valid(u_valid), .v_valid(v_valid), .consumed(consumed)
    );

    // Baseline: two valid, simple, hazard-free integer instructions.
    task automatic base();
        stall = 0;
        a_v = 1; a_fp = 0; a_s = 1; a_j = 0; a_p = 0; a_d = 0; a_i = 0;
        b_v = 1; b_fp = 0; b_s = 1; b_j = 0; b_p = 0; b_d = 0; b_i = 0;
        a_dst = 0; a_dv = 1; a_src = {2'd1, 2'd1}; a_sv = 2'b11;
        b_dst = 2; b_dv = 1; b_src = {2'd3, 2'd3}; b_sv = 2'b11;
        a_op = 4'd15; b_op = 4'd15;
    endtask

    // Reference model written from the requirements.
    function automatic bit ref_pair();
        bit raw, waw, ok;
        raw = 0;
        for (int k = 0; k < NS; k++)
            if (a_dv && b_sv[k] && a_dst == b_src[k*RW +: RW]) raw = 1;
        waw = a_dv && b_dv && (a_dst == b_dst);
        if (a_fp && b_fp)
            ok = (a_op < 10) && (b_op == 10);
        else if (!a_fp && !b_fp)
            ok = a_s && b_s && !a_j && !b_p && !(a_d && a_i) &&
                 !(b_d && b_i) && !raw && !waw;
        else
            ok = 0;
        return ok;
    endfunction

    task automatic cmp(string tag, bit eu, bit ev, logic [1:0] ec);
        n_chk++;
        if (u_valid !== eu || v_valid !== ev || consumed !== ec) begin
            n_err++;
            $display("FAIL %s: got u=%b v=%b n=%0d, expected u=%b v=%b n=%0d",
                     tag, u_valid, v_valid, consumed, eu, ev, ec);
        end
    endtask

    // Apply the current inputs over one edge and compare with the model.
    task automatic run(string tag);
        bit eu, ev;
        eu = !stall && a_v;
        ev = eu && b_v && ref_pair();
        @(negedge clk);
        cmp(tag, eu, ev, 2'(eu) + 2'(ev));
    endtask

    initial begin
        base();
        // R1: reset state
        @(negedge clk);
        cmp("R1 in reset", 0, 0, 2'd0);
        @(negedge clk);
        rst_n = 1;
        cmp("R1 after release", 0, 0, 2'd0);

        base(); run("R4 baseline pair");
        // R2
        base(); stall = 1; run("R2 stall");
        base(); a_v = 0; run("R2 I1 empty");
        // R3
        base(); b_v = 0; run("R3 I2 empty");
        // R4
        base(); a_s = 0; run("R4 I1 not simple");
        base(); b_s = 0; run("R4 I2 not simple");
        base(); a_j = 1; run("R4 I1 jump");
        base(); b_j = 1; run("R4 I2 jump allowed");
        // R5
        base(); b_src = {2'd3, 2'd0}; run("R5 raw src0");
        base(); b_src = {2'd0, 2'd3}; run("R5 raw src1");
        base(); b_src = {2'd0, 2'd0}; b_sv = 2'b00; run("R5 invalid src");
        base(); b_src = {2'd0, 2'd0}; a_dv = 0; run("R5 invalid dst");
        // R6
        base(); b_dst = 0; run("R6 waw");
        base(); b_dst = 0; b_dv = 0; run("R6 waw I2 no dst");
        // R7
        base(); a_d = 1; a_i = 1; run("R7 I1 disp+imm");
        base(); b_d = 1; b_i = 1; run("R7 I2 disp+imm");
        base(); a_d = 1; b_i = 1; run("R7 split ok");
        // R8
        base(); b_p = 1; run("R8 I2 prefix");
        base(); a_p = 1; run("R8 I1 prefix ok");
        // R9
        base(); a_fp = 1; a_op = 1; run("R9 fp then int");
        base(); b_fp = 1; b_op = 10; run("R9 int then fp");
        // R10 with integer fields set to blocking values
        base(); a_fp = 1; b_fp = 1; a_op = 0; b_op = 10;
        a_j = 1; b_p = 1; a_s = 0; b_dst = 0; b_d = 1; b_i = 1;
        run("R10 fields ignored");

        // R10: every operation-code pair
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
                base(); a_fp = 1; b_fp = 1;
                a_op = 4'(x); b_op = 4'(y);
                run("R10 op sweep");
            end

        // R5/R6: every register index and valid combination at RW=2
        for (int ad = 0; ad < 4; ad++)
            for (int bd = 0; bd < 4; bd++)
                for (int s0 = 0; s0 < 4; s0++)
                    for (int s1 = 0; s1 < 4; s1++)
                        for (int vm = 0; vm < 16; vm++) begin
                            base();
                            a_dst = 2'(ad); b_dst = 2'(bd);
                            b_src = {2'(s1), 2'(s0)};
                            a_dv = vm[0]; b_dv = vm[1]; b_sv = 2'(vm >> 2);
                            run("R5/R6 hazard sweep");
                        end

        // R2..R11: random pairs
        for (int r = 0; r < 3000; r++) begin
            logic [31:0] w;
            logic [31:0] z;
            w = $urandom; z = $urandom;
            stall = (w[3:0] == 0);
            a_v = (w[7:4] != 0); b_v = (w[11:8] != 0);
            a_fp = w[12]; b_fp = w[13];
            a_s = (w[15:14] != 0); b_s = (w[17:16] != 0);
            a_j = (w[19:18] == 0); b_j = w[20];
            a_p = w[21]; b_p = (w[23:22] == 0);
            a_d = w[24]; a_i = w[25]; b_d = w[26]; b_i = w[27];
            a_dv = w[28]; b_dv = w[29];
            a_dst = z[1:0]; b_dst = z[3:2]; a_src = z[7:4]; b_src = z[11:8];
            a_sv = z[13:12]; b_sv = z[15:14];
            a_op = z[19:16]; b_op = z[20] ? 4'd10 : z[24:21];
            run("R11 random");
        end

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: got hung run, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule